// File: doc/BRIEF.md
# Programmable Priority Highest-Pending Resolver

This block ranks interrupt sources by a table of programmable priority slots instead of by their source numbers. Each of 40 slots holds a source ID and a valid flag; slot 0 is the most urgent. The mask controller supplies three 40-bit vectors every cycle: pending, enable and route. A route bit of 1 steers a source to the fast path, and a route bit of 0 steers it to the normal path. From these vectors the block continuously selects, for each path, the enabled pending source named by the lowest-index qualifying slot.

Both winners are packed into one read-only status word. Software reads it, and reads or writes the slots, through a simple register bus with a registered read port. A typical interrupt handler reads the status word once to learn which source to service on each path. The handler does not scan the pending bits itself.

Top module: `prio_resolver`

## Requirements
- R1: A slot write keeps only data bit 31 (valid) and bits 5:0 (source ID). A slot read returns zero in every other bit position.
- R2: Slot k (k < 32) sits at byte offset 0x1C + 4k. Slot k (32 ≤ k < 40) sits at 0xB0 + 4(k − 32). Reading a slot's offset returns the value last written there.
- R3: A slot takes part in selection only when its valid bit is 1 and its source ID is below 40.
- R4: Among the slots that take part, and whose named source is both pending and enabled, the one with the lowest index wins. When two slots name the same source, the lower-index slot settles the result.
- R5: The status word is read at offset 0x18. Bits 5:0 carry the fast-path winner ID and bit 15 flags it valid. Bits 21:16 carry the normal-path winner ID and bit 31 flags it valid. All other bits read 0.
- R6: A path with no winner reports ID 0x3F and valid 0 in its field. With no winner on either path the status word reads 0x003F003F.
- R7: A source whose route bit is 1 competes only for the fast field. A source whose route bit is 0 competes only for the normal field.
- R8: The status word is read-only. A write to offset 0x18 changes neither the slots nor the status.
- R9: Synchronous reset clears every slot to zero, so every slot is invalid and the status reads 0x003F003F.
- R10: Read data appears on `rd_data` on the clock edge that samples `rd_en`. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 40 | Pending flag per source |
| src_en | input | 40 | Enable flag per source |
| src_route | input | 40 | Path per source: 1 fast, 0 normal |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: 40 slots, 40 sources, 6-bit IDs and the split slot map with 32 slots in the low window. The 6-bit ID field can name sources 40 to 63, so the bench can hold a slot valid while it names a source that does not exist, and then show that this slot never wins. The slot programming reverses the natural order of the sources, so a selection that fell back to source-number order would give wrong winners. The upper window at 0xB0 holds eight real slots, so reads and writes across both windows and the 32-slot boundary are exercised.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned VALID_BIT = 31;
  localparam int unsigned FAST_VALID_BIT = 15;
  localparam int unsigned NORM_ID_LSB = 16;
  typedef enum logic {PATH_NORMAL = 1'b0, PATH_FAST = 1'b1} path_e;
endpackage

// File: rtl/prio_slot_bank.sv
module prio_slot_bank #(
  parameter int unsigned NUM_SLOT = 40,
  parameter int unsigned ID_W     = 6,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned LO_SLOTS = 32,
  parameter int unsigned LO_BASE  = 'h1C,
  parameter int unsigned HI_BASE  = 'hB0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wr_data,
  output logic [NUM_SLOT-1:0]      slot_sel,
  output logic [NUM_SLOT-1:0]      slot_vld,
  output logic [NUM_SLOT*ID_W-1:0] slot_ids
);
  import prio_resolver_pkg::*;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    localparam int unsigned OFFS = (k < LO_SLOTS) ? (LO_BASE + 4*k)
                                                  : (HI_BASE + 4*(k - LO_SLOTS));
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(OFFS);

    assign slot_sel[k] = (addr == SLOT_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[k]              <= 1'b0;
        slot_ids[k*ID_W +: ID_W] <= '0;
      end else if (wr_en && slot_sel[k]) begin
        slot_vld[k]              <= wr_data[VALID_BIT];
        slot_ids[k*ID_W +: ID_W] <= wr_data[ID_W-1:0];
      end
    end
  end

  // R9: reset empties the whole table
  a_r9_reset_clears: assert property (@(posedge clk) rst |=> (slot_vld == '0));
  // R1/R2: a write to one slot lands only in that slot
  a_r2_single_slot_decode: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_sel));
endmodule

// File: rtl/prio_path_picker.sv
module prio_path_picker #(
  parameter int unsigned NUM_SLOT = 40,
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned ID_W     = 6,
  parameter bit          PATH     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SLOT-1:0]      slot_vld,
  input  logic [NUM_SLOT*ID_W-1:0] slot_ids,
  input  logic [NUM_SRC-1:0]       src_pend,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC-1:0]       src_route,
  output logic                     found,
  output logic [ID_W-1:0]          win_id
);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  logic [NUM_SRC-1:0] eligible;
  logic [ID_W-1:0]    sid;

  assign eligible = src_pend & src_en & (PATH ? src_route : ~src_route);

  // Scan from the least urgent slot upward so the lowest index is written last
  always_comb begin
    found  = 1'b0;
    win_id = NONE_ID;
    sid    = '0;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      sid = slot_ids[k*ID_W +: ID_W];
      if (slot_vld[k] && (32'(sid) < NUM_SRC) && eligible[sid]) begin
        found  = 1'b1;
        win_id = sid;
      end
    end
  end

  // R3/R7: a reported winner is a real, pending, enabled source on this path
  a_r3_winner_is_eligible: assert property (@(posedge clk) disable iff (rst)
    found |-> ((32'(win_id) < NUM_SRC) && src_pend[win_id] && src_en[win_id]
               && (src_route[win_id] == PATH)));
  // R6: a path without a winner reports the all-ones ID
  a_r6_empty_is_all_ones: assert property (@(posedge clk) disable iff (rst)
    !found |-> (win_id == NONE_ID));
  // R4: slot 0 naming an eligible source always decides the path
  a_r4_top_slot_wins: assert property (@(posedge clk) disable iff (rst)
    (slot_vld[0] && (32'(slot_ids[ID_W-1:0]) < NUM_SRC) && eligible[slot_ids[ID_W-1:0]])
      |-> (found && win_id == slot_ids[ID_W-1:0]));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int unsigned NUM_SLOT    = 40,
  parameter int unsigned NUM_SRC     = 40,
  parameter int unsigned ID_W        = 6,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LO_SLOTS    = 32,
  parameter int unsigned LO_BASE     = 'h1C,
  parameter int unsigned HI_BASE     = 'hB0,
  parameter int unsigned STATUS_OFFS = 'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] src_pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_route,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  import prio_resolver_pkg::*;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFFS);
  localparam int unsigned       PAD_W       = 15 - ID_W;

  logic [NUM_SLOT-1:0]      slot_sel;
  logic [NUM_SLOT-1:0]      slot_vld;
  logic [NUM_SLOT*ID_W-1:0] slot_ids;
  logic                     fast_found, norm_found;
  logic [ID_W-1:0]          fast_id, norm_id;
  logic [31:0]              status_word;
  logic [31:0]              slot_word;

  prio_slot_bank #(
    .NUM_SLOT(NUM_SLOT), .ID_W(ID_W), .ADDR_W(ADDR_W),
    .LO_SLOTS(LO_SLOTS), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .slot_sel(slot_sel), .slot_vld(slot_vld), .slot_ids(slot_ids)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic            p_found;
    logic [ID_W-1:0] p_id;
    prio_path_picker #(
      .NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC), .ID_W(ID_W), .PATH(p[0])
    ) u_pick (
      .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_ids(slot_ids),
      .src_pend(src_pend), .src_en(src_en), .src_route(src_route),
      .found(p_found), .win_id(p_id)
    );
  end

  assign fast_found = g_path[PATH_FAST].p_found;
  assign fast_id    = g_path[PATH_FAST].p_id;
  assign norm_found = g_path[PATH_NORMAL].p_found;
  assign norm_id    = g_path[PATH_NORMAL].p_id;

  assign status_word = {norm_found, {PAD_W{1'b0}}, norm_id,
                        fast_found, {PAD_W{1'b0}}, fast_id};

  always_comb begin
    slot_word = '0;
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (slot_sel[k]) begin
        slot_word[VALID_BIT] = slot_vld[k];
        slot_word[ID_W-1:0]  = slot_ids[k*ID_W +: ID_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= (addr == STATUS_ADDR) ? status_word : slot_word;
    end
  end

  // R1: slot reads never carry bits outside the kept fields
  a_r1_slot_read_clean: assert property (@(posedge clk) disable iff (rst)
    (rd_en && |slot_sel) |=> (rd_data[30:ID_W] == '0));
  // R6: an invalid path field in a status read holds the all-ones ID
  a_r6_status_empty_field: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STATUS_ADDR) |=>
      ((rd_data[FAST_VALID_BIT] || rd_data[ID_W-1:0] == '1) &&
       (rd_data[VALID_BIT] || rd_data[NORM_ID_LSB +: ID_W] == '1)));
  // R8: a write aimed at the status word leaves the slot table alone
  a_r8_status_read_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STATUS_ADDR) |=> ($stable(slot_vld) && $stable(slot_ids)));
  // R10: read data holds between reads
  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] src_pend = '0, src_en = '0, src_route = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  prio_resolver i_prio_resolver (
    .clk(clk), .rst(rst), .src_pend(src_pend), .src_en(src_en),
    .src_route(src_route), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  // Slot k names source 39-k, except slot 10 (invalid) and slot 20 (ID 45).
  localparam logic [39:0] T_PEND [NV] = '{
    40'h0, 40'h3, 40'h88, 40'h20_0000_0000 >> 8, 40'h8_0000,
    40'hC0_0000_0000, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'h08_0010_0000 };
  localparam logic [39:0] T_EN [NV] = '{
    40'h0, 40'h3, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF,
    40'h40_0000_0000, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF };
  localparam logic [39:0] T_ROUTE [NV] = '{
    40'h0, 40'h0, 40'h80, 40'h0, 40'h0,
    40'h0, 40'hFF_FFFF_FFFF, 40'h0, 40'h08_0000_0000 };
  localparam logic [31:0] T_EXP [NV] = '{
    32'h003F003F, 32'h8001003F, 32'h80038007, 32'h003F003F, 32'h003F003F,
    32'h8026003F, 32'h003F8027, 32'h8027003F, 32'h80148023 };
  localparam string T_TAG [NV] = '{
    "R6", "R4", "R7", "R3", "R3", "R5", "R7", "R4", "R5" };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] slot_addr(input int k);
    return (k < 32) ? 8'(8'h1C + 4*k) : 8'(8'hB0 + 4*(k - 32));
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    bus_read(8'h18, r);            check("R9 idle status", r, 32'h003F003F);
    bus_read(slot_addr(0), r);     check("R9 slot0 empty", r, 32'h0);
    bus_read(slot_addr(39), r);    check("R9 slot39 empty", r, 32'h0);

    // R1: unused bits dropped
    bus_write(slot_addr(0), 32'hFFFF_FFFF);
    bus_read(slot_addr(0), r);     check("R1 masked write", r, 32'h8000003F);

    // program the table
    for (int k = 0; k < 40; k++) begin
      if (k == 10)      bus_write(slot_addr(k), 32'h7FFF_FF00 | 32'(39 - k));
      else if (k == 20) bus_write(slot_addr(k), 32'h8000_002D);
      else              bus_write(slot_addr(k), 32'h8000_0000 | 32'(39 - k));
    end

    // R2: both windows
    bus_read(slot_addr(31), r);    check("R2 slot31", r, 32'h80000008);
    bus_read(8'hB4, r);            check("R2 slot33 upper window", r, 32'h80000006);
    bus_read(slot_addr(10), r);    check("R1 invalid slot", r, 32'h0000001D);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_pend = T_PEND[i]; src_en = T_EN[i]; src_route = T_ROUTE[i];
      bus_read(8'h18, r);
      check(T_TAG[i], r, T_EXP[i]);
    end

    // R4: duplicate name, lower slot decides
    bus_write(slot_addr(0), 32'h8000_0002);
    @(negedge clk);
    src_pend = 40'h20_0000_0004; src_en = '1; src_route = '0;
    bus_read(8'h18, r);            check("R4 duplicate slot", r, 32'h8002003F);

    // R8: status write ignored
    bus_write(8'h18, 32'h0000_0000);
    bus_read(8'h18, r);            check("R8 status read-only", r, 32'h8002003F);
    bus_read(slot_addr(0), r);     check("R8 slot0 untouched", r, 32'h80000002);

    // R10: rd_data holds without a read
    bus_read(8'h18, r);
    @(negedge clk);
    src_pend = '0;
    @(negedge clk);
    check("R10 hold", rd_data, 32'h8002003F);
    bus_read(8'h18, r);            check("R10 refresh", r, 32'h003F003F);

    // R9: reset again clears the table
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    src_pend = '1; src_en = '1;
    bus_read(8'h18, r);            check("R9 reset clears slots", r, 32'h003F003F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule